// File: doc/BRIEF.md
# Warp Issue Scheduler

This block chooses which resident warp gets the single instruction-dispatch port of a multithreaded core. Each warp slot presents one flag, driven from outside, which says that the operands of the warp's next instruction are available. A second flag says whether that instruction is a memory load. Among the warps that may compete, the scheduler picks one with a round-robin search. It then holds the port for a fixed number of beats and walks through the lanes of the chosen warp, one group of lanes per beat.

When a load is dispatched, the warp is parked in a pending scoreboard. It cannot compete again until a completion pulse for that warp arrives. The next selection happens in the last beat of the current dispatch, so the port runs back to back with no idle cycle between warps. When no warp can compete at a selection point, an idle output is raised and nothing is dispatched.

The defaults are 24 warp slots, 32 lanes per warp and 4 beats per dispatch, so each beat covers 8 lanes.

Top module: `warp_issue_sched`

## Requirements
- R1: A warp is eligible only when its `ready_i` bit is 1 and its `pending_o` bit is 0. A warp that is not eligible is never dispatched.
- R2: A selection made at a clock edge shows on the outputs in the following cycle. In that cycle `disp_valid_o`=1, `disp_first_o`=1, `disp_beat_o`=0, and `disp_warp_o` holds the chosen warp index. Only one warp is dispatched at a time.
- R3: A dispatch occupies the port for exactly ISSUE_CYCLES consecutive cycles (default 4). During those cycles `disp_beat_o` counts 0,1,2,3, `disp_lane_base_o` equals beat × (WARP_LANES/ISSUE_CYCLES) (0, 8, 16, 24 by default), and `disp_warp_o` stays constant.
- R4: No selection is made while the port shows beats 0 to ISSUE_CYCLES-2. A selection may be made in the cycle showing the last beat. In that case the next dispatch's beat 0 follows directly, with no gap.
- R5: Selection is round robin by warp index. The search starts at the warp after the last one dispatched, wraps from warp NUM_WARPS-1 to warp 0, and takes the first eligible warp it finds. After reset the search starts at warp 0.
- R6: When a warp whose `is_load_i` bit is 1 is selected, its `pending_o` bit becomes 1 at the same edge. The bit stays 1 until a one-cycle `ld_done_i` pulse for that warp, and it reads 0 in the cycle after the pulse.
- R7: An `ld_done_i` pulse for a warp whose pending bit is 0 has no effect on `pending_o`.
- R8: `idle_o` is 1 exactly when the port is free to select (no dispatch, or the last beat is showing) and no warp is eligible. No dispatch starts at the edge that follows a cycle with `idle_o`=1.
- R9: After reset `disp_valid_o`=0, `disp_first_o`=0 and `pending_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ready_i | input | NUM_WARPS | Per-warp operand-ready flag for its next instruction |
| is_load_i | input | NUM_WARPS | Per-warp flag: next instruction is a memory load |
| ld_done_i | input | NUM_WARPS | Per-warp load-completion pulse; clears the pending bit |
| disp_valid_o | output | 1 | Dispatch port occupied this cycle |
| disp_first_o | output | 1 | First beat of a new dispatch |
| disp_warp_o | output | $clog2(NUM_WARPS) | Warp being dispatched |
| disp_beat_o | output | $clog2(ISSUE_CYCLES) | Beat index within the dispatch |
| disp_lane_base_o | output | $clog2(WARP_LANES) | First lane covered by this beat |
| pending_o | output | NUM_WARPS | Pending-load scoreboard bits |
| idle_o | output | 1 | Selection point with no eligible warp |

## Verification
The assertions check several rules on every cycle:
- beats advance one step at a time with the warp held, and no new dispatch starts before the last beat;
- a newly started warp was ready and not pending in the selection cycle;
- its pending bit matches its load flag;
- no dispatch follows an idle cycle.

Only the bench's scenarios can show the order that the round-robin search produces across several warps, including the wrap from the top index to zero. The same holds for the lane base values of each beat, the release of a parked warp by its completion pulse, and the lack of effect of completion pulses aimed at warps that are not pending.

// File: rtl/warp_sched_pkg.sv
package warp_sched_pkg;

  // Wrap an index that may run one period past the slot count.
  function automatic int wrap_idx(input int idx, input int count);
    return (idx >= count) ? idx - count : idx;
  endfunction

  // Per-dispatch bookkeeping carried by the beat sequencer.
  typedef struct packed {
    logic       busy;
    logic [7:0] beat;
  } beat_state_t;

endpackage

// File: rtl/warp_scoreboard.sv
module warp_scoreboard #(
  parameter int NW   = 24,
  parameter int WIDX = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NW-1:0]   ready_i,
  input  logic [NW-1:0]   is_load_i,
  input  logic [NW-1:0]   ld_done_i,
  input  logic            start_i,
  input  logic [WIDX-1:0] start_warp_i,
  output logic [NW-1:0]   elig_o,
  output logic [NW-1:0]   pend_o
);

  logic [NW-1:0] pend_q;
  logic [NW-1:0] pend_d;
  logic [NW-1:0] set_vec;
  logic          pend_en;

  always_comb begin
    set_vec = '0;
    if (start_i && is_load_i[start_warp_i]) begin
      set_vec = NW'(1) << start_warp_i;
    end
    // a fresh load issue wins over a completion in the same cycle
    pend_d  = (pend_q & ~ld_done_i) | set_vec;
    pend_en = (set_vec != '0) || ((pend_q & ld_done_i) != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
    end else if (pend_en) begin
      pend_q <= pend_d;
    end
  end

  assign elig_o = ready_i & ~pend_q;
  assign pend_o = pend_q;

endmodule

// File: rtl/warp_rr_picker.sv
module warp_rr_picker #(
  parameter int NW   = 24,
  parameter int WIDX = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NW-1:0]   elig_i,
  input  logic            take_i,
  output logic            found_o,
  output logic [WIDX-1:0] pick_o
);
  import warp_sched_pkg::*;

  logic [WIDX-1:0] last_q;
  logic [WIDX-1:0] last_d;
  logic            last_en;

  always_comb begin
    found_o = 1'b0;
    pick_o  = '0;
    for (int k = 0; k < NW; k++) begin
      logic [WIDX-1:0] cand;
      cand = WIDX'(wrap_idx(int'(last_q) + 1 + k, NW));
      if (!found_o && elig_i[cand]) begin
        found_o = 1'b1;
        pick_o  = cand;
      end
    end
  end

  always_comb begin
    last_en = take_i && found_o;
    last_d  = pick_o;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q <= WIDX'(NW - 1);
    end else if (last_en) begin
      last_q <= last_d;
    end
  end

endmodule

// File: rtl/warp_beat_seq.sv
module warp_beat_seq #(
  parameter int WIDX    = 5,
  parameter int BEATS   = 4,
  parameter int BEAT_W  = 2,
  parameter int LANE_W  = 5,
  parameter int LPB     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [WIDX-1:0]   warp_i,
  output logic              can_pick_o,
  output logic              valid_o,
  output logic              first_o,
  output logic [WIDX-1:0]   warp_o,
  output logic [BEAT_W-1:0] beat_o,
  output logic [LANE_W-1:0] lane_base_o
);

  localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(BEATS - 1);

  logic              busy_q, busy_d;
  logic [BEAT_W-1:0] beat_q, beat_d;
  logic [WIDX-1:0]   warp_q, warp_d;
  logic              seq_en, warp_en;

  always_comb begin
    can_pick_o = !busy_q || (beat_q == LAST_BEAT);
    busy_d     = busy_q;
    beat_d     = beat_q;
    warp_d     = warp_i;
    warp_en    = start_i;
    if (start_i) begin
      busy_d = 1'b1;
      beat_d = '0;
    end else if (busy_q) begin
      if (beat_q == LAST_BEAT) begin
        busy_d = 1'b0;
        beat_d = '0;
      end else begin
        beat_d = beat_q + BEAT_W'(1);
      end
    end
    seq_en = start_i || busy_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      beat_q <= '0;
    end else if (seq_en) begin
      busy_q <= busy_d;
      beat_q <= beat_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      warp_q <= '0;
    end else if (warp_en) begin
      warp_q <= warp_d;
    end
  end

  assign valid_o     = busy_q;
  assign first_o     = busy_q && (beat_q == '0);
  assign warp_o      = warp_q;
  assign beat_o      = beat_q;
  assign lane_base_o = LANE_W'(int'(beat_q) * LPB);

endmodule

// File: rtl/warp_issue_sched.sv
module warp_issue_sched #(
  parameter int NUM_WARPS    = 24,
  parameter int WARP_LANES   = 32,
  parameter int ISSUE_CYCLES = 4,
  localparam int WIDX   = $clog2(NUM_WARPS),
  localparam int BEAT_W = $clog2(ISSUE_CYCLES),
  localparam int LANE_W = $clog2(WARP_LANES),
  localparam int LPB    = WARP_LANES / ISSUE_CYCLES
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_WARPS-1:0] ready_i,
  input  logic [NUM_WARPS-1:0] is_load_i,
  input  logic [NUM_WARPS-1:0] ld_done_i,
  output logic                 disp_valid_o,
  output logic                 disp_first_o,
  output logic [WIDX-1:0]      disp_warp_o,
  output logic [BEAT_W-1:0]    disp_beat_o,
  output logic [LANE_W-1:0]    disp_lane_base_o,
  output logic [NUM_WARPS-1:0] pending_o,
  output logic                 idle_o
);

  logic [NUM_WARPS-1:0] elig;
  logic                 found;
  logic [WIDX-1:0]      pick;
  logic                 can_pick;
  logic                 start;

  assign start  = can_pick && found;
  assign idle_o = can_pick && !found;

  warp_scoreboard #(.NW(NUM_WARPS), .WIDX(WIDX)) sb_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .ready_i      (ready_i),
    .is_load_i    (is_load_i),
    .ld_done_i    (ld_done_i),
    .start_i      (start),
    .start_warp_i (pick),
    .elig_o       (elig),
    .pend_o       (pending_o)
  );

  warp_rr_picker #(.NW(NUM_WARPS), .WIDX(WIDX)) pick_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .elig_i  (elig),
    .take_i  (can_pick),
    .found_o (found),
    .pick_o  (pick)
  );

  warp_beat_seq #(
    .WIDX(WIDX), .BEATS(ISSUE_CYCLES), .BEAT_W(BEAT_W),
    .LANE_W(LANE_W), .LPB(LPB)
  ) seq_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start),
    .warp_i      (pick),
    .can_pick_o  (can_pick),
    .valid_o     (disp_valid_o),
    .first_o     (disp_first_o),
    .warp_o      (disp_warp_o),
    .beat_o      (disp_beat_o),
    .lane_base_o (disp_lane_base_o)
  );

endmodule

// File: rtl/warp_issue_sched_chk.sv
module warp_issue_sched_chk #(
  parameter int NUM_WARPS    = 24,
  parameter int ISSUE_CYCLES = 4,
  parameter int WIDX   = 5,
  parameter int BEAT_W = 2
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NUM_WARPS-1:0] ready_i,
  input logic [NUM_WARPS-1:0] is_load_i,
  input logic                 disp_valid_o,
  input logic                 disp_first_o,
  input logic [WIDX-1:0]      disp_warp_o,
  input logic [BEAT_W-1:0]    disp_beat_o,
  input logic [NUM_WARPS-1:0] pending_o,
  input logic                 idle_o
);

  localparam logic [BEAT_W-1:0] LASTB = BEAT_W'(ISSUE_CYCLES - 1);

  // R3: beats step by one and the warp is held
  a_r3_beat_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_valid_o && disp_beat_o != LASTB) |=>
      (disp_valid_o && disp_beat_o == $past(disp_beat_o) + BEAT_W'(1) && $stable(disp_warp_o)));

  // R4: no new dispatch before the last beat
  a_r4_no_early_pick: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_valid_o && disp_beat_o != LASTB) |=> !disp_first_o);

  // R1: a started warp was ready and not pending when chosen
  a_r1_only_eligible: assert property (@(posedge clk) disable iff (!rst_n)
    disp_first_o |->
      ((($past(ready_i) >> disp_warp_o) & NUM_WARPS'(1)) != '0) &&
      ((($past(pending_o) >> disp_warp_o) & NUM_WARPS'(1)) == '0));

  // R6: pending bit of a started warp follows its load flag
  a_r6_pending_on_load: assert property (@(posedge clk) disable iff (!rst_n)
    disp_first_o |->
      (((pending_o >> disp_warp_o) & NUM_WARPS'(1)) ==
       (($past(is_load_i) >> disp_warp_o) & NUM_WARPS'(1))));

  // R8: idle cycle is never followed by a fresh dispatch
  a_r8_idle_no_issue: assert property (@(posedge clk) disable iff (!rst_n)
    idle_o |=> !disp_first_o);

  // R2: first beat implies port occupied at beat zero
  a_r2_first_beat: assert property (@(posedge clk) disable iff (!rst_n)
    disp_first_o |-> (disp_valid_o && disp_beat_o == '0));

endmodule

bind warp_issue_sched warp_issue_sched_chk #(
  .NUM_WARPS(NUM_WARPS), .ISSUE_CYCLES(ISSUE_CYCLES),
  .WIDX(WIDX), .BEAT_W(BEAT_W)
) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .ready_i      (ready_i),
  .is_load_i    (is_load_i),
  .disp_valid_o (disp_valid_o),
  .disp_first_o (disp_first_o),
  .disp_warp_o  (disp_warp_o),
  .disp_beat_o  (disp_beat_o),
  .pending_o    (pending_o),
  .idle_o       (idle_o)
);

// File: tb/warp_issue_sched_tb_top.sv
module warp_issue_sched_tb_top;

  localparam int NW    = 24;
  localparam int LANES = 32;
  localparam int BEATS = 4;
  localparam int LPB   = LANES / BEATS;

  logic          clk;
  logic          rst_n;
  logic [NW-1:0] ready_i, is_load_i, ld_done_i;
  logic          disp_valid_o, disp_first_o, idle_o;
  logic [4:0]    disp_warp_o;
  logic [1:0]    disp_beat_o;
  logic [4:0]    disp_lane_base_o;
  logic [NW-1:0] pending_o;

  int  n_checks = 0;
  int  n_errors = 0;
  int  last_w   = NW - 1;
  logic [NW-1:0] pend_m = '0;
  bit  finished = 0;

  warp_issue_sched #(.NUM_WARPS(NW), .WARP_LANES(LANES), .ISSUE_CYCLES(BEATS)) dut_i (
    .clk(clk), .rst_n(rst_n), .ready_i(ready_i), .is_load_i(is_load_i),
    .ld_done_i(ld_done_i), .disp_valid_o(disp_valid_o), .disp_first_o(disp_first_o),
    .disp_warp_o(disp_warp_o), .disp_beat_o(disp_beat_o),
    .disp_lane_base_o(disp_lane_base_o), .pending_o(pending_o), .idle_o(idle_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int rr_next(input logic [NW-1:0] m, input int last);
    for (int k = 1; k <= NW; k++) begin
      int c;
      c = (last + k) % NW;
      if (m[c]) return c;
    end
    return -1;
  endfunction

  // Issue n dispatches back to back from the given masks, checking every beat.
  task automatic run_seq(input int n, input logic [NW-1:0] rdy, input logic [NW-1:0] ld);
    ready_i   = rdy;
    is_load_i = ld;
    for (int i = 0; i < n; i++) begin
      int exp_w;
      exp_w = rr_next(rdy & ~pend_m, last_w);
      @(negedge clk);
      check(disp_first_o == 1'b1, "R2 first beat", disp_first_o, 1);
      check(int'(disp_warp_o) == exp_w, "R5 round-robin warp", disp_warp_o, exp_w);
      last_w = exp_w;
      if (ld[exp_w]) pend_m[exp_w] = 1'b1;
      check(pending_o == pend_m, "R6 pending after issue", pending_o, pend_m);
      if (i == n - 1) ready_i = '0;
      for (int b = 0; b < BEATS; b++) begin
        if (b > 0) @(negedge clk);
        check(disp_valid_o && int'(disp_beat_o) == b, "R3 beat index", disp_beat_o, b);
        check(int'(disp_lane_base_o) == b * LPB, "R3 lane base", disp_lane_base_o, b * LPB);
        check(int'(disp_warp_o) == exp_w, "R3 warp held", disp_warp_o, exp_w);
        if (b < BEATS - 1)
          check(idle_o == 1'b0, "R4 no selection mid-dispatch", idle_o, 0);
      end
    end
    @(negedge clk);
    check(disp_valid_o == 1'b0, "R8 port drains", disp_valid_o, 0);
    check(idle_o == 1'b1, "R8 idle when nothing eligible", idle_o, 1);
  endtask

  task automatic t_reset();
    check(disp_valid_o == 1'b0, "R9 valid after reset", disp_valid_o, 0);
    check(disp_first_o == 1'b0, "R9 first after reset", disp_first_o, 0);
    check(pending_o == '0, "R9 pending after reset", pending_o, 0);
    check(idle_o == 1'b1, "R8 idle after reset", idle_o, 1);
  endtask

  task automatic t_single_and_back_to_back();
    // warp 5 alone, issued twice back to back (R4), search starts at 0 (R5)
    run_seq(2, NW'(1) << 5, '0);
  endtask

  task automatic t_rotation();
    run_seq(5, (NW'(1) << 2) | (NW'(1) << 7) | (NW'(1) << 20), '0);
  endtask

  task automatic t_wrap();
    run_seq(1, NW'(1) << 23, '0);
    run_seq(3, (NW'(1) << 23) | NW'(1), '0); // R5 wrap to warp 0
  endtask

  task automatic t_load_park();
    run_seq(1, NW'(1) << 3, NW'(1) << 3);
    // R1: warp 3 ready but pending, must not issue
    ready_i = NW'(1) << 3;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(disp_valid_o == 1'b0, "R1 pending warp not issued", disp_valid_o, 0);
      check(idle_o == 1'b1, "R8 idle with only pending warp", idle_o, 1);
    end
    ready_i = '0;
    // R7: completion pulses to non-pending warps leave the scoreboard alone
    ld_done_i = ~(NW'(1) << 3);
    @(negedge clk);
    ld_done_i = '0;
    check(pending_o == (NW'(1) << 3), "R7 stray completion ignored", pending_o, NW'(1) << 3);
    // R6: real completion releases the warp
    ld_done_i = NW'(1) << 3;
    @(negedge clk);
    ld_done_i = '0;
    pend_m[3] = 1'b0;
    check(pending_o == '0, "R6 completion clears pending", pending_o, 0);
    run_seq(1, NW'(1) << 3, '0);
  endtask

  task automatic t_load_mixed();
    // R1/R6: loading warp parks, non-load neighbour keeps issuing
    run_seq(3, (NW'(1) << 10) | (NW'(1) << 11), NW'(1) << 10);
    ld_done_i = NW'(1) << 10;
    @(negedge clk);
    ld_done_i = '0;
    pend_m[10] = 1'b0;
    check(pending_o == '0, "R6 completion clears warp 10", pending_o, 0);
  endtask

  initial begin
    rst_n = 1'b0; ready_i = '0; is_load_i = '0; ld_done_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_single_and_back_to_back();
    t_rotation();
    t_wrap();
    t_load_park();
    t_load_mixed();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

endmodule